// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block is a single-channel transmit DMA engine. Software builds a chain of 16-byte buffer descriptors in memory and writes the address of the first descriptor into the engine. The engine then follows the chain. It fetches each descriptor over a word-wide memory request port and gathers packet bytes from the buffers the descriptors point to. It presents those bytes as a byte stream with valid/ready handshaking, and it marks the first and the last beat of each packet.

A packet may fill one descriptor or span several. The byte count of a packet is taken from its opening descriptor alone. That count can cut the packet short of the data present in its buffers. A flag on the opening descriptor turns the packet into an empty one. When a packet is done, the engine writes its status back into memory and updates a completion pointer. When the chain ends, it falls idle.

Top module: `txq_dma`

## Requirements
- R1: After reset the engine is idle: `busy`, `memReq` and `txValid` are low and `compPtr` is zero.
- R2: Writing a nonzero pointer on `headWrEn` while idle starts the walk at that descriptor. A write of zero, or any write while busy, is ignored.
- R3: A descriptor is four 32-bit words at offsets 0, 4, 8 and 12. Word 0 is the next pointer, with zero ending the chain. Word 1 is the buffer byte address. Word 2 bits 15:0 hold the buffer length. Word 3 holds start-of-packet at bit 31, end-of-packet at bit 30, ownership at bit 29, end-of-queue at bit 28, zero-byte at bit 23 and the packet length at bits 15:0.
- R4: Packet bytes are sent in buffer order and in address order within each buffer. Any byte alignment is allowed. Byte lane k of a memory word holds address 4·n+k, so the order is little-endian. A packet may span one, two or more descriptors, and middle descriptors carry neither packet flag.
- R5: The packet length is read only from the start-of-packet descriptor. The length field in later descriptors of the same packet has no effect.
- R6: When the packet length is smaller than the total buffer data, exactly that many bytes are sent. The rest of that buffer and of the packet's later buffers is skipped.
- R7: A start-of-packet descriptor with the zero-byte flag produces one beat with `txFirst`, `txLast` and `txEmpty` all high, and no data beats. The length field is ignored in that case.
- R8: `txFirst` is high on a packet's first beat and `txLast` on its final beat. While `txValid` is high and `txReady` is low, all stream outputs hold.
- R9: If the packet length exceeds the buffer data, all the data is sent without a last marker. It is followed by one beat with `txLast` and `txEmpty` high and `errOut` high (`txFirst` too if no data was sent).
- R10: After a packet's final beat, the engine rewrites word 3 of its start-of-packet descriptor with ownership cleared and the other bits kept.
- R11: End-of-queue is set in the end-of-packet descriptor of the chain's final packet and left clear in every other end-of-packet descriptor. `compPtr` then equals that packet's start-of-packet descriptor address.
- R12: After the packet whose last descriptor has a zero next pointer, the engine returns to idle and emits no more beats.
- R13: A memory request holds `memReq`, `memWe`, `memAddr` and `memWData` steady until `memAck`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headWrEn | input | 1 | Strobe to load the queue head pointer |
| headWrData | input | AW | Address of the first descriptor |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Word-aligned byte address |
| memWData | output | 32 | Write data (descriptor word 3) |
| memAck | input | 1 | Request accepted; read data valid in this cycle |
| memRData | input | 32 | Read data |
| txValid | output | 1 | Stream beat valid |
| txReady | input | 1 | Stream sink ready |
| txData | output | 8 | Stream byte |
| txFirst | output | 1 | First beat of a packet |
| txLast | output | 1 | Final beat of a packet |
| txEmpty | output | 1 | Beat carries no byte |
| errOut | output | 1 | Packet length overran the buffer data (on the closing beat) |
| busy | output | 1 | Engine walking the chain |
| compPtr | output | AW | Start descriptor of the last completed packet |

## Verification
The bench sweeps buffer alignment, the number of buffers per packet and the backpressure pattern. Each chain mixes exact, truncated, empty, one-byte and overrun packets. Non-opening descriptors carry a junk length, so an engine that reloads the length mid-packet would cut packets short or make them too long. Truncation inside the first buffer catches an engine that keeps reading later buffers and leaks their bytes. Overrun packets catch an engine that hangs, or closes without the empty error beat. After each chain the bench checks the written-back words, so a missing or misplaced end-of-queue bit, or a corrupted ownership word, shows up. A head write during a busy walk catches an engine that restarts in mid-chain.

// File: rtl/txq_dma_pkg.sv
package txq_dma_pkg;

  localparam int WORD_W   = 32;
  localparam int SOP_BIT  = 31;
  localparam int EOP_BIT  = 30;
  localparam int OWN_BIT  = 29;
  localparam int EOQ_BIT  = 28;
  localparam int ZERO_BIT = 23;

  typedef enum logic [2:0] {
    ADR_W0, ADR_W1, ADR_W2, ADR_W3, ADR_BUF, ADR_SOP3
  } addrSel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_CHECK, ST_ZERO, ST_DATA,
    ST_FETCH, ST_SEND, ST_CLOSE, ST_WBSOP, ST_WBEOQ, ST_ADV
  } txqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadHead;
    logic     ldW0;
    logic     ldW1;
    logic     ldW2;
    logic     ldW3;
    logic     ldWord;
    logic     sendByte;
    logic     markSent;
    logic     advance;
    logic     finishPkt;
    logic     wrCur;
    logic     eoqOnSop;
    addrSel_e addrSel;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic curSop;
    logic curEop;
    logic curZero;
    logic lastSent;
    logic remZero;
    logic bufZero;
    logic haveWord;
    logic nextZero;
    logic sameDesc;
  } dpStat_t;

endpackage

// File: rtl/txq_dma_dp.sv
module txq_dma_dp
  import txq_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [AW-1:0]     headIn,
  input  logic [WORD_W-1:0] memRData,
  output logic [AW-1:0]     memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic [7:0]        txData,
  output logic              firstRaw,
  output logic              lastRaw,
  output logic [AW-1:0]     compPtr,
  output dpStat_t           stat
);

  localparam logic [AW-1:0]     OFF4  = AW'(4);
  localparam logic [AW-1:0]     OFF8  = AW'(8);
  localparam logic [AW-1:0]     OFF12 = AW'(12);
  localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;
  localparam logic [WORD_W-1:0] EOQ_MASK = WORD_W'(1) << EOQ_BIT;

  logic [AW-1:0]     curPtr, nextPtr, bufPtr, sopPtr, compPtrQ;
  logic [LW-1:0]     bufRem, remLen, actLen;
  logic [WORD_W-1:0] curW3, sopW3, wordBuf;
  logic              lastSent, haveWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr    <= '0;
      nextPtr   <= '0;
      bufPtr    <= '0;
      sopPtr    <= '0;
      compPtrQ  <= '0;
      bufRem    <= '0;
      remLen    <= '0;
      actLen    <= '0;
      curW3     <= '0;
      sopW3     <= '0;
      wordBuf   <= '0;
      lastSent  <= 1'b0;
      haveWord  <= 1'b0;
    end else begin
      if (ctl.loadHead) curPtr <= headIn;
      if (ctl.advance)  curPtr <= nextPtr;
      if (ctl.ldW0)     nextPtr <= memRData[AW-1:0];
      if (ctl.ldW1) begin
        bufPtr   <= memRData[AW-1:0];
        haveWord <= 1'b0;
      end
      if (ctl.ldW2)     bufRem <= memRData[LW-1:0];
      if (ctl.ldW3) begin
        curW3 <= memRData;
        if (memRData[SOP_BIT]) begin
          sopPtr   <= curPtr;
          sopW3    <= memRData;
          remLen   <= memRData[ZERO_BIT] ? '0 : memRData[LW-1:0];
          actLen   <= '0;
          lastSent <= 1'b0;
        end
      end
      if (ctl.ldWord) begin
        wordBuf  <= memRData;
        haveWord <= 1'b1;
      end
      if (ctl.sendByte) begin
        bufPtr <= bufPtr + AW'(1);
        bufRem <= bufRem - LW'(1);
        remLen <= remLen - LW'(1);
        actLen <= actLen + LW'(1);
        if (remLen == LW'(1))     lastSent <= 1'b1;
        if (bufPtr[1:0] == 2'b11) haveWord <= 1'b0;
      end
      if (ctl.markSent)  lastSent <= 1'b1;
      if (ctl.finishPkt) compPtrQ <= sopPtr;
    end
  end

  always_comb begin
    unique case (ctl.addrSel)
      ADR_W1:   memAddr = curPtr + OFF4;
      ADR_W2:   memAddr = curPtr + OFF8;
      ADR_W3:   memAddr = curPtr + OFF12;
      ADR_BUF:  memAddr = {bufPtr[AW-1:2], 2'b00};
      ADR_SOP3: memAddr = sopPtr + OFF12;
      default:  memAddr = curPtr;
    endcase
  end

  assign memWData = ctl.wrCur ? (curW3 | EOQ_MASK)
                              : ((sopW3 & ~OWN_MASK) | (ctl.eoqOnSop ? EOQ_MASK : '0));

  assign txData   = wordBuf[{bufPtr[1:0], 3'b000} +: 8];
  assign firstRaw = (actLen == '0);
  assign lastRaw  = (remLen == LW'(1));
  assign compPtr  = compPtrQ;

  assign stat.curSop   = curW3[SOP_BIT];
  assign stat.curEop   = curW3[EOP_BIT];
  assign stat.curZero  = curW3[ZERO_BIT];
  assign stat.lastSent = lastSent;
  assign stat.remZero  = (remLen == '0);
  assign stat.bufZero  = (bufRem == '0);
  assign stat.haveWord = haveWord;
  assign stat.nextZero = (nextPtr == '0);
  assign stat.sameDesc = (curPtr == sopPtr);

  // a byte is only taken while both counters still have room
  assert_no_count_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sendByte |-> (remLen != '0) && (bufRem != '0));

endmodule

// File: rtl/txq_dma_ctrl.sv
module txq_dma_ctrl
  import txq_dma_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    headWrEn,
  input  logic    headNonZero,
  input  dpStat_t stat,
  input  logic    memAck,
  input  logic    txReady,
  output dpCtl_t  ctl,
  output logic    memReq,
  output logic    memWe,
  output logic    txValid,
  output logic    txEmpty,
  output logic    errOut,
  output logic    busy
);

  txqState_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl     = '0;
    memReq  = 1'b0;
    memWe   = 1'b0;
    txValid = 1'b0;
    txEmpty = 1'b0;
    errOut  = 1'b0;
    nxt     = state;
    unique case (state)
      ST_IDLE: if (headWrEn && headNonZero) begin
        ctl.loadHead = 1'b1;
        nxt = ST_RD0;
      end
      ST_RD0: begin
        memReq = 1'b1; ctl.addrSel = ADR_W0;
        if (memAck) begin ctl.ldW0 = 1'b1; nxt = ST_RD1; end
      end
      ST_RD1: begin
        memReq = 1'b1; ctl.addrSel = ADR_W1;
        if (memAck) begin ctl.ldW1 = 1'b1; nxt = ST_RD2; end
      end
      ST_RD2: begin
        memReq = 1'b1; ctl.addrSel = ADR_W2;
        if (memAck) begin ctl.ldW2 = 1'b1; nxt = ST_RD3; end
      end
      ST_RD3: begin
        memReq = 1'b1; ctl.addrSel = ADR_W3;
        if (memAck) begin ctl.ldW3 = 1'b1; nxt = ST_CHECK; end
      end
      ST_CHECK: nxt = (stat.curSop && stat.curZero) ? ST_ZERO : ST_DATA;
      ST_ZERO: begin
        txValid = 1'b1; txEmpty = 1'b1;
        if (txReady) begin ctl.markSent = 1'b1; nxt = ST_DATA; end
      end
      ST_DATA: begin
        if (!stat.lastSent && !stat.remZero && !stat.bufZero)
          nxt = stat.haveWord ? ST_SEND : ST_FETCH;
        else if (stat.curEop || stat.nextZero)
          nxt = stat.lastSent ? ST_WBSOP : ST_CLOSE;
        else
          nxt = ST_ADV;
      end
      ST_FETCH: begin
        memReq = 1'b1; ctl.addrSel = ADR_BUF;
        if (memAck) begin ctl.ldWord = 1'b1; nxt = ST_SEND; end
      end
      ST_SEND: begin
        txValid = 1'b1;
        if (txReady) begin ctl.sendByte = 1'b1; nxt = ST_DATA; end
      end
      ST_CLOSE: begin
        txValid = 1'b1; txEmpty = 1'b1; errOut = 1'b1;
        if (txReady) begin ctl.markSent = 1'b1; nxt = ST_WBSOP; end
      end
      ST_WBSOP: begin
        memReq = 1'b1; memWe = 1'b1; ctl.addrSel = ADR_SOP3;
        ctl.eoqOnSop = stat.sameDesc && stat.nextZero;
        if (memAck) begin
          if (!stat.sameDesc && stat.nextZero) nxt = ST_WBEOQ;
          else begin ctl.finishPkt = 1'b1; nxt = ST_ADV; end
        end
      end
      ST_WBEOQ: begin
        memReq = 1'b1; memWe = 1'b1; ctl.addrSel = ADR_W3; ctl.wrCur = 1'b1;
        if (memAck) begin ctl.finishPkt = 1'b1; nxt = ST_ADV; end
      end
      ST_ADV: begin
        if (stat.nextZero) nxt = ST_IDLE;
        else begin ctl.advance = 1'b1; nxt = ST_RD0; end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // an empty beat is always a valid beat
  assert_empty_is_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txValid);
  // a packet's status write follows only after its final beat
  assert_wb_after_send_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> stat.lastSent);

endmodule

// File: rtl/txq_dma.sv
module txq_dma
  import txq_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              headWrEn,
  input  logic [AW-1:0]     headWrData,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [WORD_W-1:0] memWData,
  input  logic              memAck,
  input  logic [WORD_W-1:0] memRData,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txFirst,
  output logic              txLast,
  output logic              txEmpty,
  output logic              errOut,
  output logic              busy,
  output logic [AW-1:0]     compPtr
);

  dpCtl_t  ctl;
  dpStat_t stat;
  logic    firstRaw, lastRaw;

  txq_dma_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .headWrEn(headWrEn), .headNonZero(|headWrData),
    .stat(stat), .memAck(memAck), .txReady(txReady), .ctl(ctl),
    .memReq(memReq), .memWe(memWe), .txValid(txValid), .txEmpty(txEmpty),
    .errOut(errOut), .busy(busy)
  );

  txq_dma_dp #(.AW(AW), .LW(LW)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .headIn(headWrData),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData),
    .txData(txData), .firstRaw(firstRaw), .lastRaw(lastRaw),
    .compPtr(compPtr), .stat(stat)
  );

  assign txFirst = txValid & firstRaw;
  assign txLast  = txValid & (txEmpty | lastRaw);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !txValid);
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWData));
  assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid && $stable(txData) && $stable(txFirst)
                              && $stable(txLast) && $stable(txEmpty));
  assert_err_closes_R9: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> txValid && txLast && txEmpty);
  assert_empty_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txLast);

endmodule

// File: tb/test_txq_dma.sv
`timescale 1ns/1ps
module test_txq_dma;

  localparam int AW = 32;
  localparam int NPKT = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        headWrEn = 1'b0;
  logic [31:0] headWrData = '0;
  logic        memReq, memWe, memAck = 1'b0;
  logic [31:0] memAddr, memWData, memRData = '0;
  logic        txValid, txReady = 1'b0, txFirst, txLast, txEmpty, errOut, busy;
  logic [7:0]  txData;
  logic [31:0] compPtr;

  txq_dma #(.AW(AW), .LW(16)) i_txq_dma (
    .clk(clk), .rstN(rstN), .headWrEn(headWrEn), .headWrData(headWrData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memAck(memAck), .memRData(memRData), .txValid(txValid), .txReady(txReady),
    .txData(txData), .txFirst(txFirst), .txLast(txLast), .txEmpty(txEmpty),
    .errOut(errOut), .busy(busy), .compPtr(compPtr)
  );

  initial forever #2.5 clk = ~clk;

  int nChk = 0, nBad = 0, cyc = 0, readyMode = 0;
  logic [31:0] mem [0:4095];

  // expected beats
  logic [7:0] expD [0:255];
  logic       expF [0:255], expL [0:255], expE [0:255], expR [0:255];
  int         expK [0:255];
  int         nExp = 0, nGot = 0;
  logic [31:0] sopP [0:NPKT-1], eopP [0:NPKT-1], sopW3 [0:NPKT-1];

  function automatic logic [7:0] pat(int a);
    return 8'(a * 13 + (a >> 5) + 7);
  endfunction

  task automatic chk(input bit ok, input string msg);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s", msg);
    end
  endtask

  // memory model: one acknowledge per request, one cycle after it is seen
  initial forever begin
    @(negedge clk);
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (memWe) mem[memAddr[13:2]] = memWData;
      else       memRData = mem[memAddr[13:2]];
      memAck = 1'b1;
    end
  end

  // sink: set ready, then capture the beat accepted at the next edge
  initial forever begin
    @(negedge clk);
    cyc++;
    case (readyMode)
      0: txReady = 1'b1;
      1: txReady = cyc[0];
      default: txReady = ((cyc * 5) % 7) < 3;
    endcase
    #1;
    if (txValid && txReady) begin
      if (nGot >= nExp) chk(0, $sformatf("R12 extra beat act=%0d exp=%0d", nGot + 1, nExp));
      else begin
        if (!expE[nGot])
          chk(txData == expD[nGot], $sformatf("R%0d data beat %0d act=%02h exp=%02h",
              expK[nGot], nGot, txData, expD[nGot]));
        chk(txFirst == expF[nGot] && txLast == expL[nGot],
            $sformatf("R8 markers beat %0d act=%b%b exp=%b%b", nGot, txFirst, txLast,
                      expF[nGot], expL[nGot]));
        chk(txEmpty == expE[nGot], $sformatf("R7 empty beat %0d act=%b exp=%b",
            nGot, txEmpty, expE[nGot]));
        chk(errOut == expR[nGot], $sformatf("R9 error beat %0d act=%b exp=%b",
            nGot, errOut, expR[nGot]));
      end
      nGot++;
    end
  end

  task automatic push(input logic [7:0] d, input logic f, input logic l,
                      input logic e, input logic r, input int k);
    expD[nExp] = d; expF[nExp] = f; expL[nExp] = l;
    expE[nExp] = e; expR[nExp] = r; expK[nExp] = k;
    nExp++;
  endtask

  // build a chain of NPKT packets with nb buffers each; fill the expected beats
  task automatic buildChain(input int off, input int nb, input int run);
    int dA = 32'h100, bA = 32'h2000 + off + 8 * run;
    nExp = 0; nGot = 0;
    for (int p = 0; p < NPKT; p++) begin
      int blen [0:2];
      int bad [0:2];
      int total = 0, L = 0, cnt = 0, kind = 4;
      logic zero = 1'b0;
      for (int k = 0; k < nb; k++) begin
        blen[k] = 2 + ((k * 3 + off + p) % 4);
        bad[k]  = bA;
        bA     += blen[k] + (k % 3);
        total  += blen[k];
      end
      case (p)
        0: begin L = total; kind = (nb > 1) ? 5 : 4; end  // R5 junk lengths later
        1: begin L = (total > 2) ? total - 2 : 1; kind = 6; end // R6
        2: begin L = 1; zero = 1'b1; end                    // R7
        3: begin L = 1; kind = 6; end                       // R6 inside first buffer
        default: L = total + 3;                             // R9
      endcase
      for (int k = 0; k < nb; k++) begin
        logic last = (p == NPKT - 1) && (k == nb - 1);
        logic [31:0] w3;
        w3 = {(k == 0), (k == nb - 1), 1'b1, 5'b0, (k == 0) && zero, 7'b0,
              (k == 0) ? 16'(L) : 16'h0055};
        mem[(dA >> 2) + 0] = last ? 32'h0 : 32'(dA + 16);
        mem[(dA >> 2) + 1] = 32'(bad[k]);
        mem[(dA >> 2) + 2] = {16'hA5A5, 16'(blen[k])};
        mem[(dA >> 2) + 3] = w3;
        if (k == 0) begin sopP[p] = 32'(dA); sopW3[p] = w3; end
        if (k == nb - 1) eopP[p] = 32'(dA);
        dA += 16;
      end
      if (zero) push(8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 7);
      else begin
        for (int k = 0; k < nb; k++)
          for (int j = 0; j < blen[k]; j++) begin
            if (cnt < L) push(pat(bad[k] + j), cnt == 0, cnt == L - 1, 1'b0, 1'b0,
                              (p == 4) ? 9 : kind);
            cnt++;
          end
        if (L > total) push(8'h00, total == 0, 1'b1, 1'b1, 1'b1, 9);
      end
    end
  endtask

  task automatic runChain(input int off, input int nb, input int run);
    int wait_n = 0;
    buildChain(off, nb, run);
    @(negedge clk); headWrEn = 1'b1; headWrData = 32'h100;
    @(negedge clk); headWrEn = 1'b0;
    #1 chk(busy == 1'b1, "R2 start on head write act=0 exp=1");
    repeat (3) @(negedge clk);
    headWrEn = 1'b1; headWrData = 32'h3F00;   // R2: ignored while busy
    @(negedge clk); headWrEn = 1'b0;
    while (busy && wait_n < 8000) begin @(negedge clk); wait_n++; end
    chk(!busy, "R12 chain did not finish act=busy exp=idle");
    repeat (12) @(negedge clk);
    chk(nGot == nExp, $sformatf("R4 beat count act=%0d exp=%0d", nGot, nExp));
    chk(!busy && !memReq, "R12 not idle after chain end");
    chk(compPtr == sopP[NPKT-1], $sformatf("R11 compPtr act=%h exp=%h",
        compPtr, sopP[NPKT-1]));
    for (int p = 0; p < NPKT; p++) begin
      logic [31:0] want, got;
      want = sopW3[p] & ~(32'h1 << 29);
      if (p == NPKT - 1 && sopP[p] == eopP[p]) want |= 32'h1 << 28;
      got = mem[(sopP[p] >> 2) + 3];
      chk(got == want, $sformatf("R10 sop word3 pkt %0d act=%h exp=%h", p, got, want));
      got = mem[(eopP[p] >> 2) + 3];
      chk(got[28] == (p == NPKT - 1), $sformatf("R11 eoq pkt %0d act=%b exp=%b",
          p, got[28], p == NPKT - 1));
      // R3: ownership of a separate end descriptor is left alone
      if (eopP[p] != sopP[p]) chk(got[29] == 1'b1, $sformatf("R3 eop owner pkt %0d act=%b exp=1", p, got[29]));
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq && !txValid && compPtr == 0,
        $sformatf("R1 reset state act=%b%b%b/%h exp=000/0", busy, memReq, txValid, compPtr));
    headWrEn = 1'b1; headWrData = 32'h0;   // R2: zero pointer ignored
    @(negedge clk); headWrEn = 1'b0;
    @(negedge clk);
    chk(!busy && !memReq, "R2 zero head started engine act=busy exp=idle");
    for (int m = 0; m < 3; m++)
      for (int off = 0; off < 4; off++)
        for (int nb = 1; nb <= 3; nb++) begin
          readyMode = m;
          runChain(off, nb, m * 12 + off * 3 + nb);
        end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL R12 watchdog expired act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule